// File: doc/BRIEF.md
# SMBus Control and Status Flag Logic

This block holds the flags that hardware updates in the control and status register of an SMBus controller. The flags are master, transmit mode, start request, stop, ACK request, arbitration lost and ACK. The bit shifter and the bus condition detectors drive single-cycle event strobes. A line-sense path reports SCL and SDA levels against what the controller is trying to drive. From these inputs the block computes the set and clear rule of every flag and registers the result. Firmware can write the start, stop and ACK flags. It can also signal that it wrote the data register or cleared the interrupt flag.

Each rule is one cycle deep: an event seen at a clock edge shows on the flag outputs right after that edge. When a hardware set and a hardware clear meet in one cycle, the set wins. A firmware write is applied only when no hardware event touches that flag in the same cycle. Three line and bus conditions raise the arbitration-lost flag. A fourth condition, a STOP seen while acting as master, drops mastership in the same way but raises the stop flag instead.

Top module: `smbf_flags`

## Requirements
- R1: While `rst_n` is low, all seven flag outputs are 0.
- R2: `master_o` becomes 1 after a cycle with `ev_start_gen`. Otherwise it becomes 0 after a cycle with `ev_stop_gen` or with any arbitration loss. An arbitration loss is one of the three triggers of R6, R7 and R8, or `ev_stop_det` while `master_o` is 1.
- R3: `txmode_o` becomes 1 after `ev_start_gen`, or after `ev_frame_start` when `fw_dat_wr` was pulsed since the previous frame start (the pulse may fall in the same cycle). Otherwise it becomes 0 after `ev_start_det`, after an arbitration loss, or after `ev_frame_start` with no such write.
- R4: `sta_o` becomes 1 after `ev_addr_rcvd`. No hardware event clears it. Only a firmware write (`fw_wr` with `fw_sta`) changes it otherwise.
- R5: `sto_o` becomes 1 after `ev_stop_det` while `slave_addressed` or `master_o` is 1. Otherwise it becomes 0 after `ev_stop_gen`.
- R6: `arblost_o` becomes 1 after `ev_rstart_det` while `master_o` is 1 and `sta_o` is 0.
- R7: `arblost_o` becomes 1 after a cycle with `line_sample` and `cond_attempt` both 1 and `scl_in` at 0.
- R8: `arblost_o` becomes 1 after a cycle with `line_sample` and `tx_one` both 1, `ack_bit` at 0 and `sda_in` at 0. During an ACK bit (`ack_bit`=1) a low SDA has no effect.
- R9: `arblost_o` becomes 0 after `fw_si_clr`, unless a trigger of R6, R7 or R8 occurs in the same cycle.
- R10: `ackrq_o` becomes 1 after `ev_byte_rcvd` while `hw_ack_en` is 0. Otherwise it becomes 0 after `ev_ack_sampled`. While `hw_ack_en` is 1, a received byte leaves it unchanged.
- R11: On `ev_ack_sampled`, `ack_o` takes the inverse of `ack_line`. A line level of 0 is an acknowledge and gives `ack_o`=1.
- R12: With `fw_wr` high, `sta_o`, `sto_o` and `ack_o` load `fw_sta`, `fw_sto` and `fw_ack`. A flag that a hardware event sets or clears in the same cycle ignores the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_ack_en | input | 1 | Hardware ACK generation enabled |
| slave_addressed | input | 1 | Controller currently addressed as slave |
| ev_start_gen | input | 1 | Pulse: START generated |
| ev_stop_gen | input | 1 | Pulse: STOP generated |
| ev_start_det | input | 1 | Pulse: START detected on bus |
| ev_stop_det | input | 1 | Pulse: STOP detected on bus |
| ev_addr_rcvd | input | 1 | Pulse: START followed by address byte received |
| ev_rstart_det | input | 1 | Pulse: repeated START detected |
| ev_byte_rcvd | input | 1 | Pulse: data byte received |
| ev_ack_sampled | input | 1 | Pulse: ACK cycle complete, level on ack_line |
| ack_line | input | 1 | Sampled SDA level of the ACK cycle |
| ev_frame_start | input | 1 | Pulse: a frame begins |
| line_sample | input | 1 | Pulse: line levels valid for comparison |
| cond_attempt | input | 1 | Attempting a STOP or repeated START |
| tx_one | input | 1 | Controller is releasing SDA to send a 1 |
| ack_bit | input | 1 | Current bit is an ACK bit |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| fw_wr | input | 1 | Firmware write of the writable flags |
| fw_sta | input | 1 | Written start value |
| fw_sto | input | 1 | Written stop value |
| fw_ack | input | 1 | Written ACK value |
| fw_dat_wr | input | 1 | Pulse: firmware wrote the data register |
| fw_si_clr | input | 1 | Pulse: firmware cleared the interrupt flag |
| master_o | output | 1 | Master flag |
| txmode_o | output | 1 | Transmit mode flag |
| sta_o | output | 1 | Start flag |
| sto_o | output | 1 | Stop flag |
| ackrq_o | output | 1 | ACK request flag |
| arblost_o | output | 1 | Arbitration lost flag |
| ack_o | output | 1 | ACK flag |

## Verification
The bench targets cycles where a set and a clear of one flag meet. A design with the wrong priority would drop master on a same-cycle START and STOP, or keep a stale arbitration loss. It drives a data-register write in the same cycle as the frame start. A design that misses it would enter receive mode when it should transmit. It drives a low SDA during an ACK bit, which a wrong design would report as lost arbitration. It drives firmware writes that collide with hardware events, where a design that lets the write win would corrupt the start or ACK flag. A repeated START with the start request high must leave arbitration untouched.

// File: rtl/smbf_pkg.sv
package smbf_pkg;

    localparam int unsigned FLAG_W = 7;

    typedef struct packed {
        logic master;
        logic txmode;
        logic sta;
        logic sto;
        logic ackrq;
        logic arblost;
        logic ack;
    } smbf_flags_t;

    // Hardware set beats hardware clear; both beat a firmware write.
    function automatic logic flag_next(input logic cur, input logic hw_set,
                                       input logic hw_clr, input logic fw_en,
                                       input logic fw_val);
        logic r;
        if (hw_set)      r = 1'b1;
        else if (hw_clr) r = 1'b0;
        else if (fw_en)  r = fw_val;
        else             r = cur;
        return r;
    endfunction

endpackage

// File: rtl/smbf_txsel.sv
module smbf_txsel (
    input  logic clk,
    input  logic rst_n,
    input  logic fw_dat_wr,
    input  logic ev_frame_start,
    output logic tx_sel_set,
    output logic tx_sel_clr
);
    typedef struct packed {
        logic pend;
    } txsel_st_t;

    txsel_st_t st_d, st_q;
    logic      written;

    always_comb begin
        st_d       = st_q;
        written    = st_q.pend | fw_dat_wr;
        tx_sel_set = ev_frame_start & written;
        tx_sel_clr = ev_frame_start & ~written;
        if (ev_frame_start) st_d.pend = 1'b0;
        else if (fw_dat_wr) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a frame start always consumes the pending write
    p_pend_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_start |=> !st_q.pend);
endmodule

// File: rtl/smbf_arb_detect.sv
module smbf_arb_detect (
    input  logic master_q,
    input  logic sta_q,
    input  logic ev_rstart_det,
    input  logic ev_stop_det,
    input  logic line_sample,
    input  logic cond_attempt,
    input  logic tx_one,
    input  logic ack_bit,
    input  logic scl_in,
    input  logic sda_in,
    output logic arb_flag_set,
    output logic arb_stop,
    output logic arb_any
);
    localparam int unsigned N_TRIG = 3;
    logic [N_TRIG-1:0] trig;

    always_comb begin
        trig[0]      = ev_rstart_det & master_q & ~sta_q;
        trig[1]      = line_sample & cond_attempt & ~scl_in;
        trig[2]      = line_sample & tx_one & ~ack_bit & ~sda_in;
        arb_flag_set = |trig;
        arb_stop     = ev_stop_det & master_q;
        arb_any      = arb_flag_set | arb_stop;
    end
endmodule

// File: rtl/smbf_flag_core.sv
module smbf_flag_core
    import smbf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hw_ack_en,
    input  logic        slave_addressed,
    input  logic        ev_start_gen,
    input  logic        ev_stop_gen,
    input  logic        ev_start_det,
    input  logic        ev_stop_det,
    input  logic        ev_addr_rcvd,
    input  logic        ev_byte_rcvd,
    input  logic        ev_ack_sampled,
    input  logic        ack_line,
    input  logic        tx_sel_set,
    input  logic        tx_sel_clr,
    input  logic        arb_flag_set,
    input  logic        arb_any,
    input  logic        fw_wr,
    input  logic        fw_sta,
    input  logic        fw_sto,
    input  logic        fw_ack,
    input  logic        fw_si_clr,
    output smbf_flags_t flags_q
);
    smbf_flags_t flags_d;

    always_comb begin
        flags_d.master  = flag_next(flags_q.master, ev_start_gen,
                                    ev_stop_gen | arb_any, 1'b0, 1'b0);
        flags_d.txmode  = flag_next(flags_q.txmode, ev_start_gen | tx_sel_set,
                                    ev_start_det | arb_any | tx_sel_clr, 1'b0, 1'b0);
        flags_d.sta     = flag_next(flags_q.sta, ev_addr_rcvd, 1'b0, fw_wr, fw_sta);
        flags_d.sto     = flag_next(flags_q.sto,
                                    ev_stop_det & (slave_addressed | flags_q.master),
                                    ev_stop_gen, fw_wr, fw_sto);
        flags_d.arblost = flag_next(flags_q.arblost, arb_flag_set, fw_si_clr, 1'b0, 1'b0);
        flags_d.ackrq   = flag_next(flags_q.ackrq, ev_byte_rcvd & ~hw_ack_en,
                                    ev_ack_sampled, 1'b0, 1'b0);
        flags_d.ack     = flag_next(flags_q.ack, ev_ack_sampled & ~ack_line,
                                    ev_ack_sampled & ack_line, fw_wr, fw_ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    p_master_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start_gen |=> flags_q.master);
    p_master_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_start_gen && ev_stop_gen) |=> !flags_q.master);
    p_sta_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_addr_rcvd && !fw_wr) |=> $stable(flags_q.sta));
    p_sto_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop_gen && !ev_stop_det) |=> !flags_q.sto);
    p_ackrq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_byte_rcvd && !hw_ack_en) |=> flags_q.ackrq);
    p_ack_seen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ack_sampled && !ack_line) |=> flags_q.ack);
    p_fw_sta_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_wr && !ev_addr_rcvd) |=> (flags_q.sta == $past(fw_sta)));
endmodule

// File: rtl/smbf_flags.sv
module smbf_flags
    import smbf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_ack_en,
    input  logic slave_addressed,
    input  logic ev_start_gen,
    input  logic ev_stop_gen,
    input  logic ev_start_det,
    input  logic ev_stop_det,
    input  logic ev_addr_rcvd,
    input  logic ev_rstart_det,
    input  logic ev_byte_rcvd,
    input  logic ev_ack_sampled,
    input  logic ack_line,
    input  logic ev_frame_start,
    input  logic line_sample,
    input  logic cond_attempt,
    input  logic tx_one,
    input  logic ack_bit,
    input  logic scl_in,
    input  logic sda_in,
    input  logic fw_wr,
    input  logic fw_sta,
    input  logic fw_sto,
    input  logic fw_ack,
    input  logic fw_dat_wr,
    input  logic fw_si_clr,
    output logic master_o,
    output logic txmode_o,
    output logic sta_o,
    output logic sto_o,
    output logic ackrq_o,
    output logic arblost_o,
    output logic ack_o
);
    smbf_flags_t flags_q;
    logic        tx_sel_set, tx_sel_clr;
    logic        arb_flag_set, arb_stop, arb_any;

    smbf_txsel u_txsel (
        .clk            (clk),
        .rst_n          (rst_n),
        .fw_dat_wr      (fw_dat_wr),
        .ev_frame_start (ev_frame_start),
        .tx_sel_set     (tx_sel_set),
        .tx_sel_clr     (tx_sel_clr)
    );

    smbf_arb_detect u_arb (
        .master_q      (flags_q.master),
        .sta_q         (flags_q.sta),
        .ev_rstart_det (ev_rstart_det),
        .ev_stop_det   (ev_stop_det),
        .line_sample   (line_sample),
        .cond_attempt  (cond_attempt),
        .tx_one        (tx_one),
        .ack_bit       (ack_bit),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .arb_flag_set  (arb_flag_set),
        .arb_stop      (arb_stop),
        .arb_any       (arb_any)
    );

    smbf_flag_core u_core (
        .clk             (clk),
        .rst_n           (rst_n),
        .hw_ack_en       (hw_ack_en),
        .slave_addressed (slave_addressed),
        .ev_start_gen    (ev_start_gen),
        .ev_stop_gen     (ev_stop_gen),
        .ev_start_det    (ev_start_det),
        .ev_stop_det     (ev_stop_det),
        .ev_addr_rcvd    (ev_addr_rcvd),
        .ev_byte_rcvd    (ev_byte_rcvd),
        .ev_ack_sampled  (ev_ack_sampled),
        .ack_line        (ack_line),
        .tx_sel_set      (tx_sel_set),
        .tx_sel_clr      (tx_sel_clr),
        .arb_flag_set    (arb_flag_set),
        .arb_any         (arb_any),
        .fw_wr           (fw_wr),
        .fw_sta          (fw_sta),
        .fw_sto          (fw_sto),
        .fw_ack          (fw_ack),
        .fw_si_clr       (fw_si_clr),
        .flags_q         (flags_q)
    );

    assign master_o  = flags_q.master;
    assign txmode_o  = flags_q.txmode;
    assign sta_o     = flags_q.sta;
    assign sto_o     = flags_q.sto;
    assign ackrq_o   = flags_q.ackrq;
    assign arblost_o = flags_q.arblost;
    assign ack_o     = flags_q.ack;

    p_rstart_arb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rstart_det && master_o && !sta_o) |=> arblost_o);
    p_scl_arb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sample && cond_attempt && !scl_in) |=> arblost_o);
    p_sda_arb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sample && tx_one && !ack_bit && !sda_in) |=> arblost_o);
    p_arb_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_si_clr && !ev_rstart_det && !line_sample) |=> !arblost_o);
    p_stop_as_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop_det && master_o && !ev_start_gen) |=> (!master_o && sto_o));
    p_tx_start_det_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start_det && !ev_start_gen && !ev_frame_start) |=> !txmode_o);
endmodule

// File: tb/smbf_flags_tb_top.sv
module smbf_flags_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic hw_ack_en, slave_addressed, ev_start_gen, ev_stop_gen, ev_start_det;
    logic ev_stop_det, ev_addr_rcvd, ev_rstart_det, ev_byte_rcvd, ev_ack_sampled;
    logic ack_line, ev_frame_start, line_sample, cond_attempt, tx_one, ack_bit;
    logic scl_in, sda_in, fw_wr, fw_sta, fw_sto, fw_ack, fw_dat_wr, fw_si_clr;
    logic master_o, txmode_o, sta_o, sto_o, ackrq_o, arblost_o, ack_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // model state: master, txmode, sta, sto, ackrq, arblost, ack, pending write
    logic m_mst, m_tx, m_sta, m_sto, m_rq, m_al, m_ack, m_pend;

    smbf_flags dut_i (.*);

    function automatic logic nx(logic cur, logic s, logic c, logic w, logic v);
        return s ? 1'b1 : (c ? 1'b0 : (w ? v : cur));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_mst, m_tx, m_sta, m_sto, m_rq, m_al, m_ack, m_pend} <= '0;
        end else begin
            logic aset, aany, wr;
            aset = (ev_rstart_det & m_mst & ~m_sta)
                 | (line_sample & cond_attempt & ~scl_in)
                 | (line_sample & tx_one & ~ack_bit & ~sda_in);
            aany = aset | (ev_stop_det & m_mst);
            wr   = m_pend | fw_dat_wr;
            m_mst  <= nx(m_mst, ev_start_gen, ev_stop_gen | aany, 1'b0, 1'b0);
            m_tx   <= nx(m_tx, ev_start_gen | (ev_frame_start & wr),
                         ev_start_det | aany | (ev_frame_start & ~wr), 1'b0, 1'b0);
            m_sta  <= nx(m_sta, ev_addr_rcvd, 1'b0, fw_wr, fw_sta);
            m_sto  <= nx(m_sto, ev_stop_det & (slave_addressed | m_mst), ev_stop_gen,
                         fw_wr, fw_sto);
            m_al   <= nx(m_al, aset, fw_si_clr, 1'b0, 1'b0);
            m_rq   <= nx(m_rq, ev_byte_rcvd & ~hw_ack_en, ev_ack_sampled, 1'b0, 1'b0);
            m_ack  <= nx(m_ack, ev_ack_sampled & ~ack_line, ev_ack_sampled & ack_line,
                         fw_wr, fw_ack);
            m_pend <= ev_frame_start ? 1'b0 : wr;
        end
    end

    task automatic cmp(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic cmp_all();
        cmp("R2 master", master_o, m_mst);
        cmp("R3 txmode", txmode_o, m_tx);
        cmp("R4 sta", sta_o, m_sta);
        cmp("R5 sto", sto_o, m_sto);
        cmp("R6/R7/R8/R9 arblost", arblost_o, m_al);
        cmp("R10 ackrq", ackrq_o, m_rq);
        cmp("R11 ack", ack_o, m_ack);
    endtask

    task automatic idle();
        {ev_start_gen, ev_stop_gen, ev_start_det, ev_stop_det, ev_addr_rcvd} = '0;
        {ev_rstart_det, ev_byte_rcvd, ev_ack_sampled, ev_frame_start, line_sample} = '0;
        {fw_wr, fw_sta, fw_sto, fw_ack, fw_dat_wr, fw_si_clr} = '0;
        {cond_attempt, tx_one, ack_bit, ack_line, hw_ack_en, slave_addressed} = '0;
        scl_in = 1'b1;
        sda_in = 1'b1;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        cmp_all();
        idle();
    endtask

    task automatic rnd();
        ev_start_gen    = ($urandom % 8) == 0;
        ev_stop_gen     = ($urandom % 8) == 0;
        ev_start_det    = ($urandom % 8) == 0;
        ev_stop_det     = ($urandom % 8) == 0;
        ev_addr_rcvd    = ($urandom % 8) == 0;
        ev_rstart_det   = ($urandom % 6) == 0;
        ev_byte_rcvd    = ($urandom % 5) == 0;
        ev_ack_sampled  = ($urandom % 5) == 0;
        ev_frame_start  = ($urandom % 7) == 0;
        line_sample     = ($urandom % 4) == 0;
        ack_line        = $urandom % 2;
        cond_attempt    = $urandom % 2;
        tx_one          = $urandom % 2;
        ack_bit         = $urandom % 2;
        scl_in          = ($urandom % 3) != 0;
        sda_in          = ($urandom % 3) != 0;
        hw_ack_en       = $urandom % 2;
        slave_addressed = $urandom % 2;
        fw_wr           = ($urandom % 6) == 0;
        fw_sta          = $urandom % 2;
        fw_sto          = $urandom % 2;
        fw_ack          = $urandom % 2;
        fw_dat_wr       = ($urandom % 6) == 0;
        fw_si_clr       = ($urandom % 6) == 0;
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", {master_o, txmode_o, sta_o, sto_o, ackrq_o, arblost_o, ack_o} == 7'd0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: start and stop generated together, set wins
        ev_start_gen = 1; ev_stop_gen = 1; cyc();
        cmp("R2 set priority", master_o, 1'b1);
        // R6: repeated START while sta high has no effect
        fw_wr = 1; fw_sta = 1; cyc();
        ev_rstart_det = 1; cyc();
        cmp("R6 sta high ignore", arblost_o, 1'b0);
        fw_wr = 1; fw_sta = 0; cyc();
        ev_rstart_det = 1; cyc();
        cmp("R6 unexpected rstart", arblost_o, 1'b1);
        cmp("R2 arb clears master", master_o, 1'b0);
        // R9: clear together with a trigger keeps the flag
        fw_si_clr = 1; line_sample = 1; cond_attempt = 1; scl_in = 0; cyc();
        cmp("R9 set priority", arblost_o, 1'b1);
        fw_si_clr = 1; cyc();
        cmp("R9 clear", arblost_o, 1'b0);
        // R8: low SDA during ACK bit ignored
        line_sample = 1; tx_one = 1; ack_bit = 1; sda_in = 0; cyc();
        cmp("R8 ack bit ignore", arblost_o, 1'b0);
        line_sample = 1; tx_one = 1; sda_in = 0; cyc();
        cmp("R8 sda low", arblost_o, 1'b1);
        fw_si_clr = 1; cyc();
        // R7
        line_sample = 1; cond_attempt = 1; scl_in = 0; cyc();
        cmp("R7 scl low", arblost_o, 1'b1);
        fw_si_clr = 1; cyc();
        // R3: data write in the frame-start cycle selects transmit
        fw_dat_wr = 1; ev_frame_start = 1; cyc();
        cmp("R3 same-cycle write", txmode_o, 1'b1);
        ev_frame_start = 1; cyc();
        cmp("R3 no write", txmode_o, 1'b0);
        // R12: firmware write loses to hardware event
        fw_wr = 1; fw_sta = 0; ev_addr_rcvd = 1; cyc();
        cmp("R12 sta hw wins", sta_o, 1'b1);
        fw_wr = 1; fw_ack = 1; ev_ack_sampled = 1; ack_line = 1; cyc();
        cmp("R12 ack hw wins", ack_o, 1'b0);
        fw_wr = 1; fw_ack = 1; fw_sto = 1; cyc();
        cmp("R12 ack written", ack_o, 1'b1);
        cmp("R12 sto written", sto_o, 1'b1);
        // R5: stop generated clears
        ev_stop_gen = 1; cyc();
        cmp("R5 stop gen clears", sto_o, 1'b0);
        ev_stop_det = 1; slave_addressed = 1; cyc();
        cmp("R5 slave stop", sto_o, 1'b1);
        // R10: hardware ACK mode leaves request low
        hw_ack_en = 1; ev_byte_rcvd = 1; cyc();
        cmp("R10 hw ack", ackrq_o, 1'b0);
        ev_byte_rcvd = 1; ev_ack_sampled = 1; cyc();
        cmp("R10 set priority", ackrq_o, 1'b1);
        ev_ack_sampled = 1; ack_line = 0; cyc();
        cmp("R10 ack cycle clears", ackrq_o, 1'b0);
        cmp("R11 ack low", ack_o, 1'b1);

        // R2..R12 random phase against the bench model
        for (int i = 0; i < 4000; i++) begin
            rnd();
            cyc();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule